// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This unit does decimal arithmetic on packed binary-coded-decimal operands, with the extend flag folded into every operation. It has three arithmetic modes. The first adds the source to the destination. The second subtracts the source from the destination. The third subtracts the destination from zero. In each mode the extend bit is also added or taken away. The unit is meant as the decimal slice of a processor's execution stage. Operand fetch and result write-back are done elsewhere. One invocation produces the decimal result and the updated condition flags.

Wider decimal numbers are handled one byte at a time, starting at the least significant byte. The carry or borrow from each byte goes into the next step as the extend bit. The zero flag is never set by this unit. A nonzero byte clears it, and a zero byte leaves it as it was. So a chain that starts with zero set ends with zero set only when every byte came out zero. The negative and overflow flags have no defined meaning after a decimal operation, so the unit drives both low. The operand width is set by the number of decimal digits, and the default is one byte (two digits). A parameter also chooses whether the outputs are registered.

Top module: `bcd_arith_unit`

## Requirements
- R1: With op_sel = 2'b00 (add), res_out equals (dst + src + x_in) mod 100, each operand read as two decimal digits with the tens digit in bits 7:4 and the ones digit in bits 3:0; c_out is 1 when the decimal sum reaches 100.
- R2: With op_sel = 2'b01 (subtract), res_out equals (dst − src − x_in) mod 100 in decimal, and c_out is 1 when the true difference is negative.
- R3: With op_sel = 2'b10 (negate), res_out equals (0 − dst − x_in) mod 100 in decimal, src_in is ignored, and c_out is 1 when the true value is negative.
- R4: For the three arithmetic modes, x_out always equals c_out.
- R5: For the three arithmetic modes, a nonzero res_out forces z_out to 0.
- R6: For the three arithmetic modes, a zero res_out makes z_out equal z_in, so a chain of bytes reports zero only if every byte is zero.
- R7: With op_sel = 2'b11 (hold), res_out equals dst_in and all five flag outputs equal their inputs.
- R8: With REG_OUT = 1 (default), the outputs follow the inputs sampled at the previous rising clock edge, and while rst_n is low all outputs are 0.
- R9: Non-decimal digits give a fixed result, one digit at a time. In add, a digit sum above 9 (carry-in included) has 6 added to it, keeps its low four bits, and sends a carry to the next digit. In subtract, a negative digit difference has 6 taken from it, keeps its low four bits, and sends a borrow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | 00 add, 01 subtract, 10 negate, 11 hold |
| dst_in | input | 4*DIGITS | Destination operand, packed decimal |
| src_in | input | 4*DIGITS | Source operand, packed decimal |
| x_in | input | 1 | Current extend flag |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| v_in | input | 1 | Current overflow flag |
| c_in | input | 1 | Current carry flag |
| res_out | output | 4*DIGITS | Decimal result |
| x_out | output | 1 | Next extend flag |
| n_out | output | 1 | Next negative flag (driven 0 for arithmetic modes) |
| z_out | output | 1 | Next zero flag |
| v_out | output | 1 | Next overflow flag (driven 0 for arithmetic modes) |
| c_out | output | 1 | Next carry flag |

## Verification
The design holds no state apart from its outputs, so an error in the digit carry chain shows at the ports on the very next clock edge. A dropped or wrong carry between digits makes the tens digit off by one. A missed correction leaves a digit above 9 or breaks x_out/c_out for that vector. A zero-flag stage that recomputes instead of keeping the old value sets z_out on a zero byte whose z_in was clear. The bench catches that within one chained step. Sweeping every valid operand pair for both extend values means every carry and borrow boundary is reached at least once.

// File: rtl/bcd_arith_pkg.sv
package bcd_arith_pkg;

   typedef enum logic [1:0] {
      BOP_ADD  = 2'b00,
      BOP_SUB  = 2'b01,
      BOP_NEG  = 2'b10,
      BOP_HOLD = 2'b11
   } bcd_op_e;

   typedef struct packed {
      logic x;
      logic n;
      logic z;
      logic v;
      logic c;
   } ccr_t;

   localparam int unsigned NIBBLE_W = 4;

endpackage

// File: rtl/bcd_nibble_cell.sv
module bcd_nibble_cell
   import bcd_arith_pkg::*;
(
   input  logic [NIBBLE_W-1:0] a_dig,
   input  logic [NIBBLE_W-1:0] b_dig,
   input  logic                sub_mode,
   input  logic                cy_in,
   output logic [NIBBLE_W-1:0] r_dig,
   output logic                cy_out
);
   logic [NIBBLE_W:0] sum_raw;
   logic [NIBBLE_W:0] dif_raw;

   always_comb begin
      sum_raw = {1'b0, a_dig} + {1'b0, b_dig} + {{NIBBLE_W{1'b0}}, cy_in};
      dif_raw = {1'b0, a_dig} - {1'b0, b_dig} - {{NIBBLE_W{1'b0}}, cy_in};
      if (!sub_mode) begin
         cy_out = (sum_raw > 5'd9);
         r_dig  = cy_out ? (sum_raw[NIBBLE_W-1:0] + 4'd6) : sum_raw[NIBBLE_W-1:0];
      end else begin
         cy_out = dif_raw[NIBBLE_W];
         r_dig  = cy_out ? (dif_raw[NIBBLE_W-1:0] - 4'd6) : dif_raw[NIBBLE_W-1:0];
      end
   end
endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
   import bcd_arith_pkg::*;
#(
   parameter int unsigned DIGITS = 2,
   localparam int unsigned W = DIGITS * NIBBLE_W
) (
   input  logic [W-1:0] a_vec,
   input  logic [W-1:0] b_vec,
   input  logic         sub_mode,
   input  logic         cy_in,
   output logic [W-1:0] r_vec,
   output logic         cy_out
);
   logic [DIGITS:0] cy;

   assign cy[0] = cy_in;

   for (genvar g = 0; g < DIGITS; g++) begin : g_dig
      bcd_nibble_cell u_cell (
         .a_dig    (a_vec[g*NIBBLE_W +: NIBBLE_W]),
         .b_dig    (b_vec[g*NIBBLE_W +: NIBBLE_W]),
         .sub_mode (sub_mode),
         .cy_in    (cy[g]),
         .r_dig    (r_vec[g*NIBBLE_W +: NIBBLE_W]),
         .cy_out   (cy[g+1])
      );
   end

   assign cy_out = cy[DIGITS];
endmodule

// File: rtl/bcd_ccr_next.sv
module bcd_ccr_next
   import bcd_arith_pkg::*;
#(
   parameter int unsigned DIGITS = 2,
   localparam int unsigned W = DIGITS * NIBBLE_W
) (
   input  bcd_op_e      op,
   input  logic [W-1:0] arith_res,
   input  logic         arith_cy,
   input  logic [W-1:0] dst_val,
   input  ccr_t         ccr_cur,
   output logic [W-1:0] res_sel,
   output ccr_t         ccr_nxt
);
   always_comb begin
      if (op == BOP_HOLD) begin
         res_sel = dst_val;
         ccr_nxt = ccr_cur;
      end else begin
         res_sel   = arith_res;
         ccr_nxt.x = arith_cy;
         ccr_nxt.c = arith_cy;
         ccr_nxt.n = 1'b0;
         ccr_nxt.v = 1'b0;
         ccr_nxt.z = (arith_res == '0) ? ccr_cur.z : 1'b0;
      end
   end
endmodule

// File: rtl/bcd_arith_unit.sv
module bcd_arith_unit
   import bcd_arith_pkg::*;
#(
   parameter int unsigned DIGITS  = 2,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned W = DIGITS * NIBBLE_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   op_sel,
   input  logic [W-1:0] dst_in,
   input  logic [W-1:0] src_in,
   input  logic         x_in,
   input  logic         n_in,
   input  logic         z_in,
   input  logic         v_in,
   input  logic         c_in,
   output logic [W-1:0] res_out,
   output logic         x_out,
   output logic         n_out,
   output logic         z_out,
   output logic         v_out,
   output logic         c_out
);
   if (DIGITS < 1) begin : g_bad_digits
      $error("bcd_arith_unit: DIGITS must be at least 1");
   end
   if (DIGITS > 16) begin : g_big_digits
      $error("bcd_arith_unit: DIGITS above 16 is not supported");
   end

   bcd_op_e      op;
   logic [W-1:0] opa, opb;
   logic         is_sub;
   logic [W-1:0] arith_res;
   logic         arith_cy;
   logic [W-1:0] res_nxt;
   ccr_t         ccr_cur, ccr_nxt;

   assign op      = bcd_op_e'(op_sel);
   assign ccr_cur = '{x: x_in, n: n_in, z: z_in, v: v_in, c: c_in};

   always_comb begin
      is_sub = (op != BOP_ADD);
      opa    = (op == BOP_NEG) ? '0     : dst_in;
      opb    = (op == BOP_NEG) ? dst_in : src_in;
   end

   bcd_digit_chain #(.DIGITS(DIGITS)) u_chain (
      .a_vec    (opa),
      .b_vec    (opb),
      .sub_mode (is_sub),
      .cy_in    (x_in),
      .r_vec    (arith_res),
      .cy_out   (arith_cy)
   );

   bcd_ccr_next #(.DIGITS(DIGITS)) u_ccr (
      .op        (op),
      .arith_res (arith_res),
      .arith_cy  (arith_cy),
      .dst_val   (dst_in),
      .ccr_cur   (ccr_cur),
      .res_sel   (res_nxt),
      .ccr_nxt   (ccr_nxt)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_out <= '0;
            x_out   <= 1'b0;
            n_out   <= 1'b0;
            z_out   <= 1'b0;
            v_out   <= 1'b0;
            c_out   <= 1'b0;
         end else begin
            res_out <= res_nxt;
            x_out   <= ccr_nxt.x;
            n_out   <= ccr_nxt.n;
            z_out   <= ccr_nxt.z;
            v_out   <= ccr_nxt.v;
            c_out   <= ccr_nxt.c;
         end
      end
   end else begin : g_comb
      assign res_out = res_nxt;
      assign x_out   = ccr_nxt.x;
      assign n_out   = ccr_nxt.n;
      assign z_out   = ccr_nxt.z;
      assign v_out   = ccr_nxt.v;
      assign c_out   = ccr_nxt.c;
   end
endmodule

// File: rtl/bcd_arith_chk.sv
module bcd_arith_chk
   import bcd_arith_pkg::*;
#(
   parameter int unsigned DIGITS  = 2,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned W = DIGITS * NIBBLE_W
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   op_sel,
   input logic [W-1:0] dst_in,
   input logic [W-1:0] src_in,
   input logic         x_in,
   input logic         n_in,
   input logic         z_in,
   input logic         v_in,
   input logic         c_in,
   input logic [W-1:0] res_out,
   input logic         x_out,
   input logic         n_out,
   input logic         z_out,
   input logic         v_out,
   input logic         c_out
);
   logic [1:0]   op_q;
   logic [W-1:0] dst_q, src_q;
   logic [4:0]   fl_q;

   if (REG_OUT) begin : g_cap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            op_q  <= 2'b00;
            dst_q <= '0;
            src_q <= '0;
            fl_q  <= '0;
         end else begin
            op_q  <= op_sel;
            dst_q <= dst_in;
            src_q <= src_in;
            fl_q  <= {x_in, n_in, z_in, v_in, c_in};
         end
      end
   end else begin : g_live
      assign op_q  = op_sel;
      assign dst_q = dst_in;
      assign src_q = src_in;
      assign fl_q  = {x_in, n_in, z_in, v_in, c_in};
   end

   function automatic bit all_decimal(input logic [W-1:0] v);
      bit ok = 1'b1;
      for (int i = 0; i < DIGITS; i++)
         if (v[i*NIBBLE_W +: NIBBLE_W] > 4'd9) ok = 1'b0;
      return ok;
   endfunction

   // R1/R2/R3: decimal operands give decimal digits
   p_digits_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != 2'b11 && all_decimal(dst_q) && all_decimal(src_q)) |-> all_decimal(res_out));

   p_x_eq_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != 2'b11) |-> (x_out == c_out));

   p_z_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != 2'b11 && res_out != '0) |-> !z_out);

   p_z_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_out == '0) |-> (z_out == fl_q[2]));

   p_hold_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == 2'b11) |-> (res_out == dst_q && {x_out, n_out, z_out, v_out, c_out} == fl_q));

   // R3: negate ignores the source operand (digits computed from dst only)
   p_neg_src_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == 2'b10 && dst_q == '0 && fl_q[4] == 1'b0) |-> (res_out == '0 && !c_out));
endmodule

bind bcd_arith_unit bcd_arith_chk #(.DIGITS(DIGITS), .REG_OUT(REG_OUT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_sel  (op_sel),
   .dst_in  (dst_in),
   .src_in  (src_in),
   .x_in    (x_in),
   .n_in    (n_in),
   .z_in    (z_in),
   .v_in    (v_in),
   .c_in    (c_in),
   .res_out (res_out),
   .x_out   (x_out),
   .n_out   (n_out),
   .z_out   (z_out),
   .v_out   (v_out),
   .c_out   (c_out)
);

// File: tb/bcd_arith_unit_tb_top.sv
module bcd_arith_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] op_sel = 2'b00;
   logic [7:0] dst_in = 8'h00, src_in = 8'h00;
   logic       x_in = 1'b0, n_in = 1'b0, z_in = 1'b0, v_in = 1'b0, c_in = 1'b0;
   logic [7:0] res_out;
   logic       x_out, n_out, z_out, v_out, c_out;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   bcd_arith_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .dst_in(dst_in), .src_in(src_in),
      .x_in(x_in), .n_in(n_in), .z_in(z_in), .v_in(v_in), .c_in(c_in),
      .res_out(res_out), .x_out(x_out), .n_out(n_out), .z_out(z_out),
      .v_out(v_out), .c_out(c_out)
   );

   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] op, input logic [7:0] d, input logic [7:0] s,
                        input logic [4:0] fl);
      @(negedge clk);
      op_sel = op; dst_in = d; src_in = s;
      {x_in, n_in, z_in, v_in, c_in} = fl;
      @(negedge clk);
   endtask

   task automatic t_reset;
      op_sel = 2'b11; dst_in = 8'h55; x_in = 1'b1; n_in = 1'b1; z_in = 1'b1; v_in = 1'b1; c_in = 1'b1;
      repeat (3) @(negedge clk);
      chk({res_out, x_out, n_out, z_out, v_out, c_out} == 13'h0, "R8 reset",
          {res_out, x_out, n_out, z_out, v_out, c_out}, 0);
      rst_n = 1'b1;
   endtask

   // one arithmetic vector against integer reference
   task automatic one_arith(input int op, input int d, input int s, input bit x, input bit z);
      int t; int r; bit cy; bit ez;
      string tg;
      if (op == 0) begin t = d + s + x; cy = (t >= 100); r = t % 100; tg = "R1"; end
      else if (op == 1) begin t = d - s - x; cy = (t < 0); r = cy ? t + 100 : t; tg = "R2"; end
      else begin t = 0 - d - x; cy = (t < 0); r = cy ? t + 100 : t; tg = "R3"; end
      ez = (r != 0) ? 1'b0 : z;
      apply(2'(op), to_bcd(d), (op == 2) ? to_bcd(s) : to_bcd(s), {x, 1'b0, z, 1'b0, 1'b0});
      chk(res_out == to_bcd(r), tg, res_out, to_bcd(r));
      chk(c_out == cy, tg, c_out, cy);
      chk(x_out == c_out, "R4", x_out, c_out);
      chk(z_out == ez, (r != 0) ? "R5" : "R6", z_out, ez);
   endtask

   task automatic t_sweep_add;
      for (int d = 0; d < 100; d++)
         for (int s = 0; s < 100; s++)
            for (int x = 0; x < 2; x++) one_arith(0, d, s, x[0], d[0] ^ s[0]);
   endtask

   task automatic t_sweep_sub;
      for (int d = 0; d < 100; d++)
         for (int s = 0; s < 100; s++)
            for (int x = 0; x < 2; x++) one_arith(1, d, s, x[0], d[0] ^ s[1]);
   endtask

   task automatic t_sweep_neg;
      for (int d = 0; d < 100; d++)
         for (int x = 0; x < 2; x++) one_arith(2, d, (d * 7) % 100, x[0], ~d[0]);
   endtask

   task automatic t_hold;
      apply(2'b11, 8'h47, 8'h99, 5'b11010);
      chk(res_out == 8'h47, "R7", res_out, 8'h47);
      chk({x_out, n_out, z_out, v_out, c_out} == 5'b11010, "R7",
          {x_out, n_out, z_out, v_out, c_out}, 5'b11010);
      apply(2'b11, 8'h00, 8'h12, 5'b00101);
      chk({res_out, x_out, n_out, z_out, v_out, c_out} == {8'h00, 5'b00101}, "R7",
          {res_out, x_out, n_out, z_out, v_out, c_out}, {8'h00, 5'b00101});
   endtask

   task automatic t_invalid;
      apply(2'b00, 8'h0F, 8'h00, 5'b00000);   // ones 15 -> 21 -> 5, carry to tens
      chk(res_out == 8'h15 && !c_out, "R9", {res_out, c_out}, {8'h15, 1'b0});
      apply(2'b01, 8'h0A, 8'h00, 5'b00000);   // ones 10, no borrow, kept
      chk(res_out == 8'h0A && !c_out, "R9", {res_out, c_out}, {8'h0A, 1'b0});
      apply(2'b01, 8'h00, 8'h0F, 5'b00000);   // ones -15 -> 0001-6 = B, tens 0-0-1 -> 9
      chk(res_out == 8'h9B && c_out, "R9", {res_out, c_out}, {8'h9B, 1'b1});
   endtask

   // two-byte chains: carry feeds extend, zero sticky across bytes
   task automatic t_chain;
      logic xc; logic zc;
      apply(2'b00, 8'h00, 8'h00, 5'b00100); xc = x_out; zc = z_out;
      apply(2'b00, 8'h00, 8'h00, {xc, 1'b0, zc, 2'b00});
      chk(z_out == 1'b1, "R6 chain all zero", z_out, 1);
      apply(2'b00, 8'h00, 8'h00, 5'b00100); xc = x_out; zc = z_out;
      apply(2'b00, 8'h01, 8'h00, {xc, 1'b0, zc, 2'b00});
      chk(z_out == 1'b0 && res_out == 8'h01, "R5 chain high nonzero", {res_out, z_out}, {8'h01, 1'b0});
      apply(2'b01, 8'h00, 8'h01, 5'b00100); xc = x_out; zc = z_out;
      chk(res_out == 8'h99 && xc, "R2 chain low", {res_out, xc}, {8'h99, 1'b1});
      apply(2'b01, 8'h01, 8'h00, {xc, 1'b0, zc, 2'b00});
      chk(res_out == 8'h00 && z_out == 1'b0 && !c_out, "R6 chain sticky clear",
          {res_out, z_out, c_out}, {8'h00, 2'b00});
   endtask

   initial begin
      t_reset();
      t_hold();
      t_invalid();
      t_chain();
      t_sweep_neg();
      t_sweep_add();
      t_sweep_sub();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule